// File: doc/BRIEF.md
# Permission Table Walker

This block resolves the 2-bit access right of one word address for one protection domain. It reads a three-level permission tree held in ordinary memory. A lookaside buffer calls on it after a miss. The buffer passes in the word address, the domain tag and the root pointer of that domain's tree. The walker then reads one entry per level through a single-outstanding memory port. It reports the resolved right, the depth at which the walk stopped and the domain tag, so that the buffer can install a refill entry whose coverage matches the depth.

Every entry is 32 bits wide. At the two upper levels, bit 0 gives the entry's kind:
- A value of 1 makes the entry a link. Bits [31:2] of a link, followed by two zero bits, form the byte address of the next table.
- A value of 0 makes the entry a leaf. Bits [2:1] of a leaf give the right for the whole span the entry covers.

A leaf stops the walk early, so one entry can grant a right over a very large span. A leaf-level entry always gives a right from bits [2:1] and pays no attention to bit 0. This lets any run of aligned words carry its own right, with no page-sized minimum.

Rights encoding: 0 = no access, 1 = read only, 2 = read and write, 3 = execute and read.

The controller has five states.
- IDLE: waits for a request.
- L1: reads the top-level entry. Each top-level entry covers 256 KB.
- L2: reads the mid-level entry. Each mid-level entry covers 256 B.
- L3: reads the word-level entry. Each word-level entry covers 4 B.
- DONE: presents the result for one cycle.

Its transitions are:
- IDLE to L1 on accept.
- L1 to L2 and L2 to L3 when a response carries a link.
- L1, L2 or L3 to DONE when a response carries a leaf, and L3 to DONE on any response.
- DONE to IDLE unconditionally.

Top module: `perm_walker`

## Requirements
- R1: While reset is held and in the first cycle after it is released, req_ready is 1, done is 0 and mem_req is 0.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. From the cycle after acceptance through the done cycle, req_ready is 0, and req_valid has no effect during that time.
- R3: In the cycle after acceptance, mem_req is 1 for exactly one cycle, with mem_addr = tbl_base + 4 * req_addr[31:18].
- R4: If the top-level response has bit 0 set, the next read is at {entry[31:2],2'b00} + 4 * req_addr[17:8].
- R5: If the mid-level response has bit 0 set, the next read is at {entry[31:2],2'b00} + 4 * req_addr[7:2]. The word-level response always ends the walk, with the right taken from bits [2:1] whatever bit 0 holds.
- R6: A top-level or mid-level response with bit 0 clear ends the walk. No further read is issued, and done_level reports 1 or 2 respectively. A walk that reaches the word level reports 3.
- R7: done is a one-cycle pulse in the cycle after the final response is taken. In that cycle done_perm, done_level and done_domain hold the walk's result and the domain tag given at acceptance.
- R8: The walker waits any number of cycles (at least one) for mem_resp_valid. It issues no new read while one is outstanding, and it ignores mem_resp_valid whenever no read is outstanding.
- R9: done_perm equals bits [2:1] of the final entry, in the encoding 0 = none, 1 = read only, 2 = read and write, 3 = execute and read.
- R10: req_ready returns to 1 in the cycle right after the done cycle, so a request held valid across the done cycle is accepted one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker can take a request |
| req_addr | input | 32 | Byte address of the word to resolve |
| req_domain | input | DOM_W (8) | Protection domain tag |
| tbl_base | input | 32 | Root table byte address for the domain |
| mem_req | output | 1 | One-cycle memory read strobe |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle result strobe |
| done_perm | output | 2 | Resolved access right |
| done_level | output | 2 | Level that supplied the right (1, 2 or 3) |
| done_domain | output | DOM_W (8) | Domain tag of the finished walk |

## Verification
Two events can meet in one cycle. The first case is the result strobe together with a still-pending new request. The bench holds req_valid high from the first request's acceptance and swaps in a second request. It then judges that req_ready stays low through the done cycle and that the second walk starts exactly one cycle later. The second case is a read response arriving while the walker is idle and has nothing outstanding. The bench injects such a stray response carrying a leaf-like entry. It then checks that no done pulse appears and that the next walk resolves correctly. A behavioural reference predicts req_ready, mem_req, mem_addr and done on every cycle, over memory latencies from one to five cycles.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1   = 3'd1,
        ST_L2   = 3'd2,
        ST_L3   = 3'd3,
        ST_DONE = 3'd4
    } walk_state_e;

    // entries are 32-bit words, so an index becomes a byte offset by this shift
    localparam int ENT_SHIFT = 2;

endpackage

// File: rtl/pw_index_gen.sv
module pw_index_gen
    import pw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int L1_LSB = 18,
    parameter int L2_LSB = 8,
    parameter int L3_LSB = 2
) (
    input  walk_state_e         state,
    input  logic [ADDR_W-1:0]   walk_addr,
    input  logic [ADDR_W-1:0]   tbl_ptr,
    output logic [ADDR_W-1:0]   entry_addr
);
    localparam int L1_W = ADDR_W - L1_LSB;
    localparam int L2_W = L1_LSB - L2_LSB;
    localparam int L3_W = L2_LSB - L3_LSB;

    logic [L1_W-1:0]   idx1;
    logic [L2_W-1:0]   idx2;
    logic [L3_W-1:0]   idx3;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        idx1 = walk_addr[ADDR_W-1:L1_LSB];
        idx2 = walk_addr[L1_LSB-1:L2_LSB];
        idx3 = walk_addr[L2_LSB-1:L3_LSB];
        unique case (state)
            ST_L1:   offset = ADDR_W'(idx1) << ENT_SHIFT;
            ST_L2:   offset = ADDR_W'(idx2) << ENT_SHIFT;
            ST_L3:   offset = ADDR_W'(idx3) << ENT_SHIFT;
            default: offset = '0;
        endcase
        entry_addr = tbl_ptr + offset;
    end

endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              is_link,
    output logic [1:0]        perm,
    output logic [ADDR_W-1:0] next_ptr
);
    always_comb begin
        is_link  = entry[0];
        perm     = entry[2:1];
        next_ptr = {entry[ADDR_W-1:2], 2'b00};
    end

endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
    import pw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_resp_valid,
    input  logic        entry_is_link,
    output walk_state_e state,
    output logic        req_ready,
    output logic        accept,
    output logic        mem_req,
    output logic        resp_take
);
    walk_state_e state_nxt;
    logic        waiting;
    logic        in_level;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // one outstanding read at a time
    always_ff @(posedge clk) begin
        if (!rst_n)         waiting <= 1'b0;
        else if (resp_take) waiting <= 1'b0;
        else if (mem_req)   waiting <= 1'b1;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept)    state_nxt = ST_L1;
            ST_L1:   if (resp_take) state_nxt = entry_is_link ? ST_L2 : ST_DONE;
            ST_L2:   if (resp_take) state_nxt = entry_is_link ? ST_L3 : ST_DONE;
            ST_L3:   if (resp_take) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_L1, ST_L2, ST_L3: in_level = 1'b1;
            default:             in_level = 1'b0;
        endcase
        req_ready = (state == ST_IDLE);
        accept    = req_ready && req_valid;
        mem_req   = in_level && !waiting;
        resp_take = in_level && waiting && mem_resp_valid;
    end

endmodule

// File: rtl/perm_walker.sv
module perm_walker
    import pw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DOM_W  = 8,
    parameter int L1_LSB = 18,
    parameter int L2_LSB = 8,
    parameter int L3_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DOM_W-1:0]  req_domain,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_resp_valid,
    input  logic [ADDR_W-1:0] mem_resp_data,
    output logic              done,
    output logic [1:0]        done_perm,
    output logic [1:0]        done_level,
    output logic [DOM_W-1:0]  done_domain
);
    walk_state_e       state;
    logic              accept;
    logic              resp_take;
    logic              ent_is_link;
    logic [1:0]        ent_perm;
    logic [ADDR_W-1:0] ent_next;
    logic [ADDR_W-1:0] walk_addr;
    logic [ADDR_W-1:0] walk_ptr;
    logic [DOM_W-1:0]  walk_dom;
    logic [1:0]        res_perm;
    logic [1:0]        res_level;
    logic [1:0]        lvl_code;
    logic              descend;

    pw_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .mem_resp_valid (mem_resp_valid),
        .entry_is_link  (ent_is_link),
        .state          (state),
        .req_ready      (req_ready),
        .accept         (accept),
        .mem_req        (mem_req),
        .resp_take      (resp_take)
    );

    pw_index_gen #(
        .ADDR_W (ADDR_W),
        .L1_LSB (L1_LSB),
        .L2_LSB (L2_LSB),
        .L3_LSB (L3_LSB)
    ) u_idx (
        .state      (state),
        .walk_addr  (walk_addr),
        .tbl_ptr    (walk_ptr),
        .entry_addr (mem_addr)
    );

    pw_entry_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .entry    (mem_resp_data),
        .is_link  (ent_is_link),
        .perm     (ent_perm),
        .next_ptr (ent_next)
    );

    always_comb begin
        unique case (state)
            ST_L1:   lvl_code = 2'd1;
            ST_L2:   lvl_code = 2'd2;
            ST_L3:   lvl_code = 2'd3;
            default: lvl_code = 2'd0;
        endcase
        descend = ent_is_link && (state != ST_L3);
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_addr <= '0;
            walk_ptr  <= '0;
            walk_dom  <= '0;
            res_perm  <= '0;
            res_level <= '0;
        end else begin
            if (accept) begin
                walk_addr <= req_addr;
                walk_dom  <= req_domain;
                walk_ptr  <= tbl_base;
            end
            if (resp_take) begin
                if (descend) begin
                    walk_ptr <= ent_next;
                end else begin
                    res_perm  <= ent_perm;
                    res_level <= lvl_code;
                end
            end
        end
    end

    always_comb begin
        done        = (state == ST_DONE);
        done_perm   = res_perm;
        done_level  = res_level;
        done_domain = walk_dom;
    end

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int DOM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req,
    input logic             mem_resp_valid,
    input logic             done,
    input logic [1:0]       done_level,
    input logic [DOM_W-1:0] done_domain
);
    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    no_ready_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    // R3
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    level_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_level != 2'd0));

    // R8
    done_needs_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_resp_valid));

    // R10
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R7
    domain_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(req_ready)) |-> $stable(done_domain));

endmodule

bind perm_walker pw_checker #(.DOM_W(DOM_W)) u_pw_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_req        (mem_req),
    .mem_resp_valid (mem_resp_valid),
    .done           (done),
    .done_level     (done_level),
    .done_domain    (done_domain)
);

// File: tb/sim_perm_walker.sv
module sim_perm_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_domain = '0;
    logic [31:0] tbl_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        done;
    logic [1:0]  done_perm;
    logic [1:0]  done_level;
    logic [7:0]  done_domain;

    always #5 clk = ~clk;

    perm_walker u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_domain     (req_domain),
        .tbl_base       (tbl_base),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .done           (done),
        .done_perm      (done_perm),
        .done_level     (done_level),
        .done_domain    (done_domain)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] memory [logic [31:0]];

    // reference model state
    logic [31:0] exp_addrs[$];
    string       exp_tags[$];
    logic [1:0]  exp_perm;
    logic [1:0]  exp_level;
    logic [7:0]  exp_dom;
    bit          busy = 0;
    bit          done_due = 0;
    bit          req_due = 0;
    bit          pending = 0;
    bit          pend_final = 0;
    int          cnt = 0;
    int          lat = 1;
    logic [31:0] pend_addr;
    bit          stray = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return memory.exists(a) ? memory[a] : 32'h0;
    endfunction

    // expected walk derived from the table contents
    task automatic plan_walk(input logic [31:0] a, input logic [31:0] b, input logic [7:0] d);
        logic [31:0] ea;
        logic [31:0] e;
        exp_addrs.delete();
        exp_tags.delete();
        exp_dom = d;
        ea = b + ((a >> 18) << 2);
        exp_addrs.push_back(ea); exp_tags.push_back("R3");
        e = rd(ea);
        if (!e[0]) begin exp_perm = e[2:1]; exp_level = 2'd1; return; end
        ea = {e[31:2], 2'b00} + (((a >> 8) & 32'h3FF) << 2);
        exp_addrs.push_back(ea); exp_tags.push_back("R4");
        e = rd(ea);
        if (!e[0]) begin exp_perm = e[2:1]; exp_level = 2'd2; return; end
        ea = {e[31:2], 2'b00} + (((a >> 2) & 32'h3F) << 2);
        exp_addrs.push_back(ea); exp_tags.push_back("R5");
        e = rd(ea);
        exp_perm  = e[2:1];
        exp_level = 2'd3;
    endtask

    // cycle-by-cycle comparison and memory model
    always @(negedge clk) begin
        if (rst_n) begin
            bit nxt_req;
            bit nxt_done;
            nxt_req  = 0;
            nxt_done = 0;
            // R2 R10: ready low exactly while a walk is in flight
            chk(req_ready == !busy, "R2,R10", "req_ready", 32'(req_ready), 32'(!busy));
            chk(done == done_due, "R7", "done", 32'(done), 32'(done_due));
            chk(mem_req == req_due, "R8", "mem_req", 32'(mem_req), 32'(req_due));
            if (done_due && done) begin
                chk(done_perm == exp_perm, "R9", "done_perm", 32'(done_perm), 32'(exp_perm));
                chk(done_level == exp_level, "R6", "done_level", 32'(done_level), 32'(exp_level));
                chk(done_domain == exp_dom, "R7", "done_domain", 32'(done_domain), 32'(exp_dom));
            end
            if (done_due) busy = 0;
            if (pending) begin
                cnt--;
                if (cnt == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = rd(pend_addr);
                    pending = 0;
                    if (pend_final) nxt_done = 1; else nxt_req = 1;
                end else begin
                    mem_resp_valid = 1'b0;
                end
            end else if (stray && !busy) begin
                mem_resp_valid = 1'b1;
                mem_resp_data  = 32'h0000_0007;
            end else begin
                mem_resp_valid = 1'b0;
            end
            if (mem_req && exp_addrs.size() > 0) begin
                chk(mem_addr == exp_addrs[0], exp_tags[0], "mem_addr", mem_addr, exp_addrs[0]);
                pend_final = (exp_addrs.size() == 1);
                void'(exp_addrs.pop_front());
                void'(exp_tags.pop_front());
                pending   = 1;
                cnt       = lat;
                pend_addr = mem_addr;
            end
            if (req_valid && req_ready) begin
                busy = 1;
                plan_walk(req_addr, tbl_base, req_domain);
                nxt_req = 1;
            end
            done_due = nxt_done;
            req_due  = nxt_req;
        end
    end

    task automatic walk(input logic [31:0] a, input logic [31:0] b, input logic [7:0] d, input int l);
        @(posedge clk); #1;
        lat = l; req_valid = 1'b1; req_addr = a; tbl_base = b; req_domain = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1 req_valid = 1'b0;
        do @(negedge clk); while (!done);
    endtask

    localparam logic [31:0] ROOT_A = 32'h0001_0000;
    localparam logic [31:0] ROOT_B = 32'h0005_0000;
    localparam logic [31:0] MID_T  = 32'h0002_0000;
    localparam logic [31:0] LEAF_T = 32'h0003_0000;

    initial begin
        // tables
        memory[ROOT_A + 32'h0]        = 32'h0000_0004;          // top idx 0: leaf RW
        memory[ROOT_A + 32'h4]        = MID_T | 32'h1;          // top idx 1: link
        memory[MID_T + 32'd20]        = 32'h0000_0002;          // mid idx 5: leaf RO
        memory[MID_T + 32'd24]        = LEAF_T | 32'h1;         // mid idx 6: link
        memory[LEAF_T + 32'd0]        = 32'h0000_0006;          // word 0: XR
        memory[LEAF_T + 32'd4]        = 32'h0000_0000;          // word 1: none
        memory[LEAF_T + 32'd252]      = 32'h0000_0005;          // word 63: RW, bit0 set
        memory[ROOT_B + 32'h0000_FFFC] = 32'h0000_0006;         // last top idx: leaf XR

        // R1 reset state
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'h1);
        chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'h0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;

        walk(32'h0000_1234, ROOT_A, 8'h11, 1);   // R6 top-level leaf
        walk(32'h0004_0520, ROOT_A, 8'h22, 3);   // R4 mid-level leaf
        walk(32'h0004_0600, ROOT_A, 8'h33, 1);   // R5 word level XR
        walk(32'h0004_0604, ROOT_A, 8'h44, 5);   // R9 none
        walk(32'h0004_06FC, ROOT_A, 8'h55, 2);   // R5 bit0 ignored at word level
        walk(32'hFFFC_0010, ROOT_B, 8'h66, 4);   // R3 highest top index
        walk(32'h0123_4560, ROOT_A, 8'h77, 2);   // unmapped: none at level 1

        // R2 R10: request held across the done cycle
        @(posedge clk); #1;
        lat = 2; req_valid = 1'b1; req_addr = 32'h0004_0600; tbl_base = ROOT_A; req_domain = 8'hA1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1 req_addr = 32'h0004_0500; req_domain = 8'hA2;
        do @(negedge clk); while (!done);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after done", 32'(req_ready), 32'h1);
        @(posedge clk); #1 req_valid = 1'b0;
        do @(negedge clk); while (!done);
        chk(done_domain == 8'hA2, "R2", "second walk domain", 32'(done_domain), 32'hA2);

        // R8 stray response while idle
        repeat (2) @(posedge clk);
        #1 stray = 1;
        @(posedge clk); #1 stray = 0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R8", "done after stray response", 32'(done), 32'h0);
        chk(req_ready == 1'b1, "R8", "ready after stray response", 32'(req_ready), 32'h1);
        walk(32'h0004_0604, ROOT_A, 8'hB0, 1);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule